// File: doc/BRIEF.md
# Flash Power Settle Wait Sequencer

This block stalls the processor while the flash array supply recovers. A wait always follows the release of reset. A wait also follows some exits from low-power modes, depending on which mode is being left and on two power-down control bits. While the processor is stalled, interrupt requests are still captured. Their service is held back until the wait is over, so no handler runs while the flash supply is unsettled. During the wait that follows reset the peripherals are frozen too. During every later wait they keep running.

The wait length is counted in ticks of one of two clock enables. The fast enable is used when the exit lands in the full-speed mode. The slow enable is used when it lands in the low-speed mode. Mode-exit events arrive as a one-cycle valid strobe with a 3-bit code. Interrupt requests are single-cycle pulses that are OR-ed into per-source pending latches. One latch is serviced at a time, and each service is announced by a one-hot strobe.

Top module: `flash_settle_seq`

## Requirements
- R1: While `rst` is high, and after its release until `LONG_WAIT` ticks of `hf_tick` have been counted, `cpu_halt`, `periph_halt` and `wait_active` are 1 and `irq_svc` is 0. This holds whatever value `flash_ctl` has.
- R2: Codes 0 (stop to full-speed) and 1 (stop to low-speed) start a wait only when `flash_ctl` bit 0 is 1.
- R3: Codes 2 (idle to full-speed) and 3 (sleep to low-speed) start a wait only when `flash_ctl` bit 1 is 0.
- R4: A wait started by code 0 or 1 lasts `LONG_WAIT` ticks. A wait started by code 2 or 3 lasts `SHORT_WAIT` ticks.
- R5: Waits from codes 0 and 2 count only `hf_tick`. Waits from codes 1 and 3 count only `lf_tick`. The other enable has no effect on the length.
- R6: During a wait started by a mode-exit event, `cpu_halt` is 1 and `periph_halt` is 0.
- R7: `wait_active` rises in the cycle after a qualifying event. It falls at the clock edge that counts the last tick.
- R8: An event that arrives while a wait is active is dropped. It neither extends the wait nor starts a new one once the wait ends.
- R9: A request pulse that arrives during a wait sets its latch. No service strobe appears during the wait. When `irq_master_en` is 1, the strobe appears in the cycle after `wait_active` falls.
- R10: While `irq_master_en` is 0, no service strobe is issued and pending latches are kept.
- R11: `irq_svc` is one-hot, serves the lowest-index pending source first, issues at most one source per cycle, and clears that source's latch.
- R12: An event that does not qualify (including codes 4 to 7) causes no halt. A pending interrupt is then served in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Mode-exit event strobe |
| evt_code | input | 3 | Mode-exit kind (0..3 defined, 4..7 reserved) |
| flash_ctl | input | 2 | Bit 0: main power-down; bit 1: automatic power-down |
| hf_tick | input | 1 | Fast clock enable |
| lf_tick | input | 1 | Slow clock enable |
| irq_req | input | IRQ_N | Interrupt request pulses |
| irq_master_en | input | 1 | Interrupt master enable |
| cpu_halt | output | 1 | Processor stall |
| periph_halt | output | 1 | Peripheral freeze (reset wait only) |
| wait_active | output | 1 | Wait in progress |
| irq_svc | output | IRQ_N | One-hot service strobe |

## Verification
Each of the four defined exit codes is driven with both settings of the bit that gates it. This separates the control bit for stop exits from the one for idle and sleep exits. The slow enable is pulsed sparsely while the fast enable stays high, so a wait that counts the wrong enable ends early and is caught. Directed sequences cover these cases:
- an event injected in the middle of a wait;
- requests that arrive during a wait;
- requests held back by the master enable;
- reserved codes with a pending request.

A long seeded random run then mixes events, control bits, ticks, requests and occasional resets, and compares every output in every cycle against a cycle model in the bench.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam logic [2:0] EVT_STOP_NORM  = 3'd0;
  localparam logic [2:0] EVT_STOP_SLOW  = 3'd1;
  localparam logic [2:0] EVT_IDLE_NORM  = 3'd2;
  localparam logic [2:0] EVT_SLEEP_SLOW = 3'd3;

  localparam int CTL_MAIN_PD = 0;
  localparam int CTL_AUTO_PD = 1;

  typedef struct packed {
    logic go;    // start a wait
    logic slow;  // count the slow enable
    logic lng;   // use the long length
  } wait_req_t;
endpackage

// File: rtl/fsw_event_qual.sv
module fsw_event_qual
  import fsw_pkg::*;
(
  input  logic       evt_valid,
  input  logic [2:0] evt_code,
  input  logic [1:0] flash_ctl,
  input  logic       busy,
  output wait_req_t  req
);
  always_comb begin
    req = '0;
    if (evt_valid && !busy) begin
      case (evt_code)
        EVT_STOP_NORM: begin
          req.go   = flash_ctl[CTL_MAIN_PD];
          req.slow = 1'b0;
          req.lng  = 1'b1;
        end
        EVT_STOP_SLOW: begin
          req.go   = flash_ctl[CTL_MAIN_PD];
          req.slow = 1'b1;
          req.lng  = 1'b1;
        end
        EVT_IDLE_NORM: begin
          req.go   = !flash_ctl[CTL_AUTO_PD];
          req.slow = 1'b0;
          req.lng  = 1'b0;
        end
        EVT_SLEEP_SLOW: begin
          req.go   = !flash_ctl[CTL_AUTO_PD];
          req.slow = 1'b1;
          req.lng  = 1'b0;
        end
        default: req = '0;
      endcase
    end
  end
endmodule

// File: rtl/fsw_wait_timer.sv
module fsw_wait_timer
  import fsw_pkg::*;
#(
  parameter int LONG_WAIT  = 1024,
  parameter int SHORT_WAIT = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  wait_req_t start,
  input  logic      hf_tick,
  input  logic      lf_tick,
  output logic      active,
  output logic      periph_hold
);
  localparam int MAXW = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_WAIT - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_WAIT - 1);

  logic [CW-1:0] cnt;
  logic          use_slow;
  logic          use_long;
  logic          tick;
  logic [CW-1:0] last;

  assign tick = use_slow ? lf_tick : hf_tick;
  assign last = use_long ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b1;
      periph_hold <= 1'b1;
      cnt         <= '0;
      use_slow    <= 1'b0;
      use_long    <= 1'b1;
    end else if (active) begin
      if (tick) begin
        if (cnt == last) begin
          active      <= 1'b0;
          periph_hold <= 1'b0;
          cnt         <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (start.go) begin
      active   <= 1'b1;
      cnt      <= '0;
      use_slow <= start.slow;
      use_long <= start.lng;
    end
  end
endmodule

// File: rtl/fsw_irq_latch.sv
module fsw_irq_latch #(
  parameter int IRQ_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_N-1:0] irq_req,
  input  logic             allow,
  output logic [IRQ_N-1:0] irq_svc
);
  logic [IRQ_N-1:0] pend;
  logic [IRQ_N-1:0] pick;
  logic [IRQ_N-1:0] clr;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign pick[i] = pend[i];
    end else begin : g_rest
      assign pick[i] = pend[i] & ~(|pend[i-1:0]);
    end
  end

  assign clr = allow ? pick : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      irq_svc <= '0;
    end else begin
      pend    <= (pend & ~clr) | irq_req;
      irq_svc <= clr;
    end
  end
endmodule

// File: rtl/flash_settle_seq.sv
module flash_settle_seq
  import fsw_pkg::*;
#(
  parameter int LONG_WAIT  = 1024,
  parameter int SHORT_WAIT = 8,
  parameter int IRQ_N      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic [2:0]       evt_code,
  input  logic [1:0]       flash_ctl,
  input  logic             hf_tick,
  input  logic             lf_tick,
  input  logic [IRQ_N-1:0] irq_req,
  input  logic             irq_master_en,
  output logic             cpu_halt,
  output logic             periph_halt,
  output logic             wait_active,
  output logic [IRQ_N-1:0] irq_svc
);
  wait_req_t req;
  logic      active;
  logic      hold;
  logic      allow;

  fsw_event_qual u_qual (
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .flash_ctl (flash_ctl),
    .busy      (active),
    .req       (req)
  );

  fsw_wait_timer #(
    .LONG_WAIT  (LONG_WAIT),
    .SHORT_WAIT (SHORT_WAIT)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .start       (req),
    .hf_tick     (hf_tick),
    .lf_tick     (lf_tick),
    .active      (active),
    .periph_hold (hold)
  );

  // service only when no wait is running or about to start
  assign allow = irq_master_en && !active && !req.go;

  fsw_irq_latch #(
    .IRQ_N (IRQ_N)
  ) u_irq (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .allow   (allow),
    .irq_svc (irq_svc)
  );

  assign cpu_halt    = active;
  assign wait_active = active;
  assign periph_halt = hold;
endmodule

// File: rtl/flash_settle_chk.sv
module flash_settle_chk #(
  parameter int IRQ_N = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_valid,
  input logic             hf_tick,
  input logic             lf_tick,
  input logic             irq_master_en,
  input logic             cpu_halt,
  input logic             periph_halt,
  input logic             wait_active,
  input logic [IRQ_N-1:0] irq_svc
);
  AST_PERIPH_NEEDS_CPU: assert property (@(posedge clk) disable iff (rst)
    periph_halt |-> cpu_halt); // R6
  AST_PERIPH_NO_REARM: assert property (@(posedge clk) disable iff (rst)
    !periph_halt |=> !periph_halt); // R6
  AST_NO_SVC_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    wait_active |-> (irq_svc == '0)); // R9
  AST_SVC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_svc)); // R11
  AST_SVC_NEEDS_IME: assert property (@(posedge clk) disable iff (rst)
    (irq_svc != '0) |-> $past(irq_master_en)); // R10
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    (wait_active && !hf_tick && !lf_tick) |=> wait_active); // R5
  AST_IDLE_WITHOUT_EVT: assert property (@(posedge clk) disable iff (rst)
    (!wait_active && !evt_valid) |=> !wait_active); // R7
endmodule

bind flash_settle_seq flash_settle_chk #(.IRQ_N(IRQ_N)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .evt_valid     (evt_valid),
  .hf_tick       (hf_tick),
  .lf_tick       (lf_tick),
  .irq_master_en (irq_master_en),
  .cpu_halt      (cpu_halt),
  .periph_halt   (periph_halt),
  .wait_active   (wait_active),
  .irq_svc       (irq_svc)
);

// File: tb/flash_settle_seq_bench.sv
module flash_settle_seq_bench;
  localparam int LW = 64;
  localparam int SW = 5;
  localparam int N  = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         evt_valid;
  logic [2:0]   evt_code;
  logic [1:0]   flash_ctl;
  logic         hf_tick;
  logic         lf_tick;
  logic [N-1:0] irq_req;
  logic         ime;
  logic         cpu_halt;
  logic         periph_halt;
  logic         wait_active;
  logic [N-1:0] irq_svc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  bit         m_wait, m_per, m_slow, m_lng;
  int         m_cnt;
  bit [N-1:0] m_pend, m_svc;

  always #5 clk = ~clk;

  flash_settle_seq #(.LONG_WAIT(LW), .SHORT_WAIT(SW), .IRQ_N(N)) u_flash_settle_seq (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
    .flash_ctl(flash_ctl), .hf_tick(hf_tick), .lf_tick(lf_tick),
    .irq_req(irq_req), .irq_master_en(ime), .cpu_halt(cpu_halt),
    .periph_halt(periph_halt), .wait_active(wait_active), .irq_svc(irq_svc)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit qual(logic [2:0] c, logic [1:0] ctl);
    if (c == 3'd0 || c == 3'd1) return ctl[0];
    if (c == 3'd2 || c == 3'd3) return !ctl[1];
    return 1'b0;
  endfunction

  task automatic model_step(bit r, bit ev, logic [2:0] c, logic [1:0] ctl,
                            bit hf, bit lf, bit [N-1:0] rq, bit ie);
    bit go, t;
    bit [N-1:0] g;
    if (r) begin
      m_wait = 1; m_per = 1; m_cnt = 0; m_lng = 1; m_slow = 0;
      m_pend = '0; m_svc = '0;
      return;
    end
    go = ev && !m_wait && qual(c, ctl);
    g = '0;
    if (!m_wait && !go && ie) begin
      for (int i = N - 1; i >= 0; i--) if (m_pend[i]) g = N'(1) << i;
    end
    m_pend = (m_pend & ~g) | rq;
    m_svc  = g;
    if (m_wait) begin
      t = m_slow ? lf : hf;
      if (t) begin
        if (m_cnt == (m_lng ? LW : SW) - 1) begin
          m_wait = 0; m_per = 0; m_cnt = 0;
        end else m_cnt++;
      end
    end else if (go) begin
      m_wait = 1; m_cnt = 0;
      m_slow = (c == 3'd1 || c == 3'd3);
      m_lng  = (c < 3'd2);
    end
  endtask

  // one clock: model follows the inputs seen at the edge, compare at negedge
  task automatic cyc();
    bit r = rst, ev = evt_valid, hf = hf_tick, lf = lf_tick, ie = ime;
    logic [2:0] c = evt_code;
    logic [1:0] ctl = flash_ctl;
    bit [N-1:0] rq = irq_req;
    @(posedge clk);
    model_step(r, ev, c, ctl, hf, lf, rq, ie);
    @(negedge clk);
    chk(wait_active === m_wait, "R7 wait_active vs model", 32'(wait_active), 32'(m_wait));
    chk(cpu_halt === m_wait, "R2 cpu_halt vs model", 32'(cpu_halt), 32'(m_wait));
    chk(periph_halt === m_per, "R6 periph_halt vs model", 32'(periph_halt), 32'(m_per));
    chk(irq_svc === m_svc, "R11 irq_svc vs model", 32'(irq_svc), 32'(m_svc));
  endtask

  task automatic pulse_evt(logic [2:0] c, logic [1:0] ctl);
    evt_valid = 1; evt_code = c; flash_ctl = ctl;
    cyc();
    evt_valid = 0;
  endtask

  task automatic count_wait(output int n);
    n = 0;
    while (wait_active && n < 10000) begin cyc(); n++; end
  endtask

  initial begin
    int n, ticks;
    bit lfg;
    rst = 1; evt_valid = 0; evt_code = 0; flash_ctl = 2'b10;
    hf_tick = 1; lf_tick = 0; irq_req = 0; ime = 1;
    cyc(); cyc();
    // R1 reset state
    chk(cpu_halt && periph_halt && wait_active && irq_svc == 0,
        "R1 halts during reset", {cpu_halt, periph_halt, wait_active}, 3'b111);
    rst = 0;
    count_wait(n);
    chk(n == LW, "R1 reset wait length", n, LW);
    chk(!periph_halt, "R1 periph released", periph_halt, 0);

    // R2 stop exit gated by bit 0
    pulse_evt(3'd0, 2'b00);
    chk(!wait_active, "R2 stop exit, main bit 0", wait_active, 0);
    pulse_evt(3'd0, 2'b01);
    chk(wait_active, "R7 rise after event", wait_active, 1);
    chk(cpu_halt && !periph_halt, "R6 cpu only", {cpu_halt, periph_halt}, 2'b10);
    count_wait(n);
    chk(n == LW, "R4 long wait on fast ticks", n, LW);

    // R3 sleep exit gated by bit 1; R5 slow count
    pulse_evt(3'd3, 2'b11);
    chk(!wait_active, "R3 sleep exit, auto bit 1", wait_active, 0);
    pulse_evt(3'd3, 2'b00);
    chk(wait_active, "R3 sleep exit, auto bit 0", wait_active, 1);
    ticks = 0; n = 0;
    while (wait_active && n < 1000) begin
      lfg = (n % 3 == 0); lf_tick = lfg;
      cyc(); n++;
      if (lfg) ticks++;
    end
    lf_tick = 0;
    chk(ticks == SW, "R5 slow ticks counted", ticks, SW);
    chk(n > SW, "R5 fast ticks ignored", n, SW + 1);

    // R8 event during wait dropped
    pulse_evt(3'd2, 2'b00);
    cyc(); cyc();
    pulse_evt(3'd0, 2'b01);
    count_wait(n);
    chk(n == SW - 3, "R8 wait not extended", n, SW - 3);
    cyc();
    chk(!wait_active, "R8 no late start", wait_active, 0);

    // R9 latch during wait, serve after
    pulse_evt(3'd2, 2'b01);
    irq_req = 4'b0100; cyc(); irq_req = 0;
    while (wait_active) begin
      chk(irq_svc == 0, "R9 no service in wait", irq_svc, 0);
      cyc();
    end
    cyc();
    chk(irq_svc == 4'b0100, "R9 served after wait", irq_svc, 4'b0100);
    cyc();
    chk(irq_svc == 0, "R11 single strobe", irq_svc, 0);

    // R10 master enable holds, R11 priority
    ime = 0; irq_req = 4'b1010; cyc(); irq_req = 0;
    cyc(); cyc();
    chk(irq_svc == 0, "R10 held with ime 0", irq_svc, 0);
    ime = 1; cyc();
    chk(irq_svc == 4'b0010, "R11 lowest first", irq_svc, 4'b0010);
    cyc();
    chk(irq_svc == 4'b1000, "R11 next source", irq_svc, 4'b1000);
    cyc();
    chk(irq_svc == 0, "R11 latch cleared", irq_svc, 0);

    // R12 reserved code passes pending through
    ime = 0; irq_req = 4'b0001; cyc(); irq_req = 0;
    ime = 1;
    pulse_evt(3'd5, 2'b01);
    chk(!wait_active, "R12 reserved code no halt", wait_active, 0);
    chk(irq_svc == 4'b0001, "R12 served next cycle", irq_svc, 4'b0001);

    // random phase
    void'($urandom(32'd2024));
    for (int k = 0; k < 4000; k++) begin
      rst       = ($urandom % 600) == 0;
      evt_valid = ($urandom % 12) == 0;
      evt_code  = 3'($urandom % 8);
      flash_ctl = 2'($urandom);
      hf_tick   = ($urandom % 4) != 0;
      lf_tick   = ($urandom % 5) == 0;
      irq_req   = (($urandom % 6) == 0) ? N'($urandom) : '0;
      ime       = ($urandom % 8) != 0;
      cyc();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule